// File: doc/BRIEF.md
# Keyed register write-protection guard

This block sits on a simple register bus, between the bus master and a peripheral's register file. It decodes each write, decides whether the target register is currently protected, and either forwards the write to the peripheral as a one-hot per-register write enable or drops it and logs a violation. Reads of the peripheral's registers pass through, and the block answers reads of its own two registers.

Protection is held in a 32-bit protection mode register. Its three enable bits can change only when the upper 24 bits of the write carry a fixed key. Each enable covers one class of peripheral register: the general enable covers every peripheral register, the interrupt enable covers the interrupt-enable and interrupt-disable registers, and the control enable covers the control register. A dropped write sets a sticky flag and records the offending address in a violation status register. Reading that register clears the flag.

Every access completes in one cycle with no wait states. Write enables, forwarded write data and read data are all registered, so they appear in the cycle after the bus strobe.

Top module: `regwr_guard`

## Requirements
- R1: After synchronous reset, all three protection enables are 0, the violation flag is 0, the recorded address is 0 and no per-register write enable is asserted.
- R2: A write to byte address 0xE4 whose bits 31:8 equal 0x535243 loads the enables from the write data: bit 2 is the control enable, bit 1 the interrupt enable and bit 0 the general enable.
- R3: A write to 0xE4 whose bits 31:8 hold any other value leaves all three enables unchanged.
- R4: A read of 0xE4 returns the enables in bits 2:0 and zero in bits 31:3, including the key field. Read data appears in the cycle after the read strobe.
- R5: While the general enable is set, a write to any peripheral register (word index 0 to NUM_REGS-1, byte address 4×index) is dropped.
- R6: While the interrupt enable is set, writes to byte addresses 0x10 and 0x14 are dropped, and no other address is affected by this enable.
- R7: While the control enable is set, writes to byte address 0x00 are dropped, and no other address is affected by this enable.
- R8: A write that is not dropped asserts exactly the write-enable bit of its word index, for exactly one cycle, in the cycle after the strobe, and presents the write data on the forwarded data output in that cycle.
- R9: A dropped write asserts no write enable. It sets the violation flag (bit 0 of the status register at 0xE8) and stores the write's byte address, zero-extended to 16 bits, in status bits 23:8. The other status bits read 0. A later violation overwrites the address.
- R10: A read of 0xE8 returns the status as it stood before the read, then clears the flag. The recorded address is kept. A violation in the same cycle wins over the clear.
- R11: The mode register is never protected: with all enables set, a keyed write to 0xE4 still changes the enables and logs no violation.
- R12: Writes to 0xE8 or to any address outside the peripheral range and the mode register assert no write enable, change no state and log no violation, whatever the enables.
- R13: A read of a peripheral address returns the peripheral read data sampled with the strobe. A read of an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_rd |
| per_rdata | input | 32 | Read data from the peripheral for the current address |
| per_we | output | NUM_REGS | One-hot registered write enable per peripheral register |
| per_wdata | output | 32 | Registered write data for the peripheral |

## Verification
The bench sweeps all eight enable combinations and, for each one, writes every peripheral register once and then reads the status register after each write. This catches a design that applies an enable to the wrong class, misses the general enable on the control or interrupt registers, or lets an enable leak onto neighbouring registers. Near-miss keys (one bit off, byte-swapped, all ones, zero) are aimed at a key comparator that checks only part of the field. A keyed write that clears the enables while all of them are set catches a guard that protects its own mode register. Back-to-back violations followed by two status reads expose a flag that is not sticky, an address that keeps the first offender instead of the latest, and a read that clears the recorded address along with the flag.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  localparam logic [23:0] WP_KEY   = 24'h535243;
  localparam int          MODE_OFS = 'hE4;
  localparam int          STAT_OFS = 'hE8;

  // class of the addressed register
  typedef enum logic [1:0] {
    GRP_NONE = 2'd0,
    GRP_CTRL = 2'd1,
    GRP_INTR = 2'd2,
    GRP_CONF = 2'd3
  } grp_e;

  typedef struct packed {
    logic ctrl;
    logic intr;
    logic gen;
  } wp_en_t;
endpackage

// File: rtl/wprot_classify.sv
module wprot_classify
  import wprot_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 32,
  parameter int CTRL_IDX = 0,
  parameter int IEN_IDX  = 4,
  parameter int IDIS_IDX = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_mode,
  output logic              is_stat,
  output logic              is_per,
  output logic [ADDR_W-3:0] word_idx,
  output grp_e              grp
);
  localparam int WIDX_W = ADDR_W - 2;

  always_comb begin
    word_idx = addr[ADDR_W-1:2];
    is_mode  = (addr == ADDR_W'(MODE_OFS));
    is_stat  = (addr == ADDR_W'(STAT_OFS));
    is_per   = ({1'b0, word_idx} < (WIDX_W + 1)'(NUM_REGS));
    if (!is_per)
      grp = GRP_NONE;
    else if (word_idx == WIDX_W'(CTRL_IDX))
      grp = GRP_CTRL;
    else if (word_idx == WIDX_W'(IEN_IDX) || word_idx == WIDX_W'(IDIS_IDX))
      grp = GRP_INTR;
    else
      grp = GRP_CONF;
  end
endmodule

// File: rtl/wprot_mode_reg.sv
module wprot_mode_reg
  import wprot_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  logic        sel,
  input  logic [23:0] key,
  input  logic [2:0]  val,
  output wp_en_t      en
);
  always_ff @(posedge clk) begin
    if (rst)
      en <= '0;
    else if (wr && sel && key == WP_KEY)
      en <= wp_en_t'(val);
  end
endmodule

// File: rtl/wprot_status.sv
module wprot_status (
  input  logic        clk,
  input  logic        rst,
  input  logic        viol,
  input  logic [15:0] viol_addr,
  input  logic        rd_clr,
  output logic        flag,
  output logic [15:0] addr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag   <= 1'b0;
      addr_q <= '0;
    end else if (viol) begin
      flag   <= 1'b1;
      addr_q <= viol_addr;
    end else if (rd_clr) begin
      flag   <= 1'b0;
    end
  end
endmodule

// File: rtl/regwr_guard.sv
module regwr_guard
  import wprot_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 32,
  parameter int CTRL_IDX = 0,
  parameter int IEN_IDX  = 4,
  parameter int IDIS_IDX = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [31:0]         per_rdata,
  output logic [NUM_REGS-1:0] per_we,
  output logic [31:0]         per_wdata
);
  localparam int WIDX_W = ADDR_W - 2;

  logic              is_mode, is_stat, is_per;
  logic [WIDX_W-1:0] word_idx;
  grp_e              grp;
  wp_en_t            mode_en;
  logic              stat_flag;
  logic [15:0]       stat_addr;
  logic              blocked, wr_viol, wr_pass;

  wprot_classify #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS),
    .CTRL_IDX(CTRL_IDX), .IEN_IDX(IEN_IDX), .IDIS_IDX(IDIS_IDX)
  ) u_cls (
    .addr(bus_addr), .is_mode(is_mode), .is_stat(is_stat),
    .is_per(is_per), .word_idx(word_idx), .grp(grp)
  );

  wprot_mode_reg u_mode (
    .clk(clk), .rst(rst), .wr(bus_wr), .sel(is_mode),
    .key(bus_wdata[31:8]), .val(bus_wdata[2:0]), .en(mode_en)
  );

  always_comb begin
    blocked = (mode_en.gen  && is_per) ||
              (mode_en.intr && grp == GRP_INTR) ||
              (mode_en.ctrl && grp == GRP_CTRL);
    wr_viol = bus_wr && blocked;
    wr_pass = bus_wr && is_per && !blocked;
  end

  wprot_status u_stat (
    .clk(clk), .rst(rst), .viol(wr_viol), .viol_addr(16'(bus_addr)),
    .rd_clr(bus_rd && is_stat), .flag(stat_flag), .addr_q(stat_addr)
  );

  // one registered enable per peripheral register
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_we
    always_ff @(posedge clk) begin
      if (rst) per_we[g] <= 1'b0;
      else     per_we[g] <= wr_pass && (word_idx == WIDX_W'(g));
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          per_wdata <= '0;
    else if (wr_pass) per_wdata <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (is_mode)      bus_rdata <= {29'd0, mode_en};
      else if (is_stat) bus_rdata <= {8'd0, stat_addr, 7'd0, stat_flag};
      else if (is_per)  bus_rdata <= per_rdata;
      else              bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/regwr_guard_chk.sv
module regwr_guard_chk
  import wprot_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [23:0]         key_in,
  input logic [2:0]          val_in,
  input logic [NUM_REGS-1:0] per_we,
  input logic [2:0]          en_bits,
  input logic                flag,
  input logic                viol
);
  logic at_mode, at_stat, at_per;
  always_comb begin
    at_mode = (bus_addr == ADDR_W'(MODE_OFS));
    at_stat = (bus_addr == ADDR_W'(STAT_OFS));
    at_per  = ({2'b00, bus_addr} >> 2) < (ADDR_W + 2)'(NUM_REGS);
  end

  assert_key_load_R2: assert property (@(posedge clk) disable iff (rst)
    bus_wr && at_mode && key_in == WP_KEY |=> en_bits == $past(val_in));

  assert_key_gate_R3: assert property (@(posedge clk) disable iff (rst)
    bus_wr && at_mode && key_in != WP_KEY |=> $stable(en_bits));

  assert_gen_block_R5: assert property (@(posedge clk) disable iff (rst)
    bus_wr && at_per && en_bits[0] |-> viol);

  assert_onehot_we_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(per_we));

  assert_we_needs_write_R8: assert property (@(posedge clk) disable iff (rst)
    (|per_we) |-> $past(bus_wr));

  assert_drop_logs_R9: assert property (@(posedge clk) disable iff (rst)
    viol |=> flag && per_we == '0);

  assert_read_clears_R10: assert property (@(posedge clk) disable iff (rst)
    bus_rd && at_stat && !viol |=> !flag);

  assert_mode_free_R11: assert property (@(posedge clk) disable iff (rst)
    bus_wr && at_mode |-> !viol);

  assert_stat_ignored_R12: assert property (@(posedge clk) disable iff (rst)
    bus_wr && !at_per |-> !viol);
endmodule

bind regwr_guard regwr_guard_chk #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .key_in(bus_wdata[31:8]), .val_in(bus_wdata[2:0]), .per_we(per_we),
  .en_bits(mode_en), .flag(stat_flag), .viol(wr_viol)
);

// File: tb/regwr_guard_test.sv
module regwr_guard_test;
  localparam int NREG = 32;
  localparam logic [7:0]  A_MODE = 8'hE4;
  localparam logic [7:0]  A_STAT = 8'hE8;
  localparam logic [23:0] KEY    = 24'h535243;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]      bus_addr = '0;
  logic [31:0]     bus_wdata = '0, per_rdata = '0;
  logic [31:0]     bus_rdata, per_wdata;
  logic [NREG-1:0] per_we;

  int n_chk = 0, n_fail = 0;
  logic [NREG-1:0] we_obs;
  logic [31:0]     wd_obs, rd_obs;
  logic [15:0]     last_va = '0;

  always #10 clk = ~clk;

  regwr_guard #(.ADDR_W(8), .NUM_REGS(NREG)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .per_rdata(per_rdata),
    .per_we(per_we), .per_wdata(per_wdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    we_obs = per_we; wd_obs = per_wdata;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    rd_obs = bus_rdata; we_obs = per_we;
  endtask

  function automatic logic [31:0] stat_word(input logic [15:0] a, input logic f);
    return {8'd0, a, 7'd0, f};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic       blk;
    string      req;
    logic [31:0] wd;
    logic [NREG-1:0] exp_we;

    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state
    chk(per_we == '0, "R1 we", 32'(per_we), 0);
    rd(A_MODE); chk(rd_obs == 0, "R1 mode", rd_obs, 0);
    rd(A_STAT); chk(rd_obs == 0, "R1 status", rd_obs, 0);

    // sweep every enable combination over every peripheral register
    for (int m = 0; m < 8; m++) begin
      wr(A_MODE, {KEY, 5'd0, 3'(m)});
      rd(A_MODE); chk(rd_obs == 32'(m), "R2 keyed load", rd_obs, 32'(m));
      for (int i = 0; i < NREG; i++) begin
        blk = m[0] || (m[1] && (i == 4 || i == 5)) || (m[2] && i == 0);
        if (!blk)      req = "R8";
        else if (m[0]) req = "R5";
        else if (i == 0) req = "R7";
        else           req = "R6";
        wd = 32'hA5000000 ^ (i * 32'h01010101) ^ 32'(m);
        wr(8'(i * 4), wd);
        exp_we = blk ? '0 : (NREG'(1) << i);
        chk(we_obs == exp_we, req, 32'(we_obs), 32'(exp_we));
        if (!blk) chk(wd_obs == wd, "R8 data", wd_obs, wd);
        if (blk) last_va = 16'(i * 4);
        rd(A_STAT);
        chk(rd_obs == stat_word(last_va, blk), "R9 status", rd_obs, stat_word(last_va, blk));
        chk(we_obs == '0, "R8 single cycle", 32'(we_obs), 0);
      end
    end

    // R10: sticky flag, latest address, clear on read keeps address
    wr(A_MODE, {KEY, 8'h01});
    wr(8'h08, 32'h1);
    wr(8'h0C, 32'h2);
    rd(A_STAT); chk(rd_obs == stat_word(16'h000C, 1'b1), "R10 first read", rd_obs, stat_word(16'h000C, 1'b1));
    rd(A_STAT); chk(rd_obs == stat_word(16'h000C, 1'b0), "R10 after clear", rd_obs, stat_word(16'h000C, 1'b0));
    last_va = 16'h000C;

    // R3: wrong keys leave enables alone
    wr(A_MODE, {KEY, 8'h05});
    wr(A_MODE, {24'h000000, 8'h02});
    wr(A_MODE, {24'h535242, 8'h02});
    wr(A_MODE, {24'h535343, 8'h02});
    wr(A_MODE, {24'hFFFFFF, 8'h02});
    wr(A_MODE, {24'h435253, 8'h02});
    rd(A_MODE); chk(rd_obs == 32'h5, "R3 wrong keys", rd_obs, 32'h5);

    // R4: key field and spare bits read as zero
    wr(A_MODE, {KEY, 8'hFF});
    rd(A_MODE); chk(rd_obs == 32'h7, "R4 readback", rd_obs, 32'h7);

    // R11: mode register reachable while fully protected
    wr(A_MODE, {KEY, 8'h00});
    rd(A_MODE); chk(rd_obs == 32'h0, "R11 unlock", rd_obs, 0);
    rd(A_STAT); chk(rd_obs == stat_word(last_va, 1'b0), "R11 no violation", rd_obs, stat_word(last_va, 1'b0));

    // R12: status and unmapped writes do nothing, even with general enable
    wr(A_STAT, 32'hFFFFFFFF); chk(we_obs == '0, "R12 status write", 32'(we_obs), 0);
    wr(8'hF0, 32'h12345678);  chk(we_obs == '0, "R12 unmapped write", 32'(we_obs), 0);
    wr(A_MODE, {KEY, 8'h01});
    wr(8'hF0, 32'h1);         chk(we_obs == '0, "R12 unmapped protected", 32'(we_obs), 0);
    wr(A_STAT, 32'h1);
    rd(A_STAT); chk(rd_obs == stat_word(last_va, 1'b0), "R12 status intact", rd_obs, stat_word(last_va, 1'b0));

    // R13: read pass-through and unmapped reads
    per_rdata = 32'hCAFE1234;
    rd(8'h1C); chk(rd_obs == 32'hCAFE1234, "R13 peripheral read", rd_obs, 32'hCAFE1234);
    rd(8'hF0); chk(rd_obs == 32'h0, "R13 unmapped read", rd_obs, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule